// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is the host end of a two-wire PHY management bus. It produces the management clock, drives the bidirectional data line through an output enable, and reads back what the PHY returns. Software sees seven 32-bit registers, selected by a 3-bit address with a write strobe and a read strobe. Read data is combinational from the address.

There are three ways to use the block. Bit-bang mode hands the clock, data and enable pins straight to three one-bit registers. Frame mode takes one 32-bit command word. The engine sends it after a preamble of ones, then flags completion with a valid bit. On a read, it also returns the 16 data bits from the PHY. Poll mode runs only while bit-bang is off. It reads one configured PHY register over and over and keeps the last value seen. It collects the bits that changed since the previous poll and raises an interrupt for any changed bit that is not masked.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `mdc_o`, `mdio_oe` and `irq_o` are 0. Reading address 4 (config) returns 0, address 5 (mask) returns 0x0000FFFF, address 3 (frame) returns 0 and address 6 (poll status) returns 0.
- R2: While a frame is on the bus, each half period of MDC lasts CLK_HALF clocks, so a full period is 2*CLK_HALF clocks. Each bit starts with MDC low. When no frame is active, MDC rests low.
- R3: Every frame begins with 32 bits of 1, driven with `mdio_oe` high, before the first bit of the command word.
- R4: After the preamble, the 32 bits of the frame register are sent MSB first. Bits 31:30 are the start code 01. Bits 29:28 are the opcode, 10 for read and 01 for write. Bits 27:23 are the PHY address, 22:18 the register address, 17:16 the turnaround and 15:0 the data. Outside a frame, `mdio_o` is 1.
- R5: On a read (opcode 10), `mdio_oe` goes low from the first turnaround bit to the end of the frame. On a write, `mdio_oe` stays high for the whole frame.
- R6: On a read, `mdio_i` is sampled on each rising MDC edge of the 16 data bits, MSB first. When the frame completes, bit 16 of the frame register (valid) reads 1 and bits 15:0 hold the captured data. A write frame keeps its loaded data bits.
- R7: Writing address 3 clears the valid bit. The frame starts on the next clock if the engine is idle and bit-bang mode is off.
- R8: Config bit 0 selects bit-bang mode. While it is set, `mdc_o`, `mdio_o` and `mdio_oe` equal bit 0 of addresses 0, 1 and 2, and no frame starts. A frame written meanwhile waits and is sent once bit 0 is cleared.
- R9: Config bit 1 (with bit 0 clear) starts back-to-back read frames to the PHY address in config bits 14:10 and the register address in config bits 7:3. Bits 31:16 of address 6 hold the last value polled.
- R10: Bits 15:0 of address 6 collect, sticky, the XOR of each polled value with the one before it. The first poll after poll mode is enabled adds nothing. A read of address 6 clears these bits.
- R11: `irq_o` is 1 exactly when some changed bit has a 0 in the same position of the mask register (address 5, bits 15:0). A mask bit of 1 suppresses that bit.
- R12: A frame written while poll mode runs waits for the poll frame in flight to finish. It is then sent before the next poll frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears poll changes at address 6) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven to the pad |
| mdio_oe | output | 1 | Pad output enable |
| irq_o | output | 1 | Unmasked poll change present |

## Verification
The assertions assume that software does not change bit-bang or poll configuration, and does not rewrite the frame register, while a frame is on the bus. They also assume `reg_wr` and `reg_rd` are each held for one clock. The stimulus follows these rules: it waits on the valid bit before each new command, and it only switches bit-bang mode while the engine is idle. Poll mode is the one exception: the bench writes a frame while polling, because the block queues it by design. The bench's PHY model drives `mdio_i` only while the engine has released the line, returning a turnaround 0 followed by its current register value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_AW    = 3;
    localparam int FRM_BITS  = 32;
    localparam int DATA_BITS = 16;

    typedef enum logic [REG_AW-1:0] {
        RA_BB_CLK = 3'd0,
        RA_BB_DAT = 3'd1,
        RA_BB_OE  = 3'd2,
        RA_FRAME  = 3'd3,
        RA_CFG    = 3'd4,
        RA_MASK   = 3'd5,
        RA_STAT   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        logic       poll_en;
        logic       bb_sel;
    } cfg_t;

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] TA_HOST = 2'b10;

    function automatic logic is_read_op(input logic [FRM_BITS-1:0] w);
        return w[29:28] == OP_RD;
    endfunction

    function automatic logic [FRM_BITS-1:0] poll_frame(input logic [4:0] phy,
                                                       input logic [4:0] regad);
        return {ST_CODE, OP_RD, phy, regad, TA_HOST, {DATA_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic                 sw_launch,
    input  logic                 sw_done,
    input  logic [DATA_BITS-1:0] rx_data,
    input  logic [DATA_BITS-1:0] poll_last,
    input  logic [DATA_BITS-1:0] poll_chg,
    output cfg_t                 cfg_q,
    output logic [DATA_BITS-1:0] mask_q,
    output logic                 bb_clk_q,
    output logic                 bb_dat_q,
    output logic                 bb_oe_q,
    output logic [FRM_BITS-1:0]  frame_q,
    output logic                 pend_q,
    output logic                 valid_q,
    output logic                 stat_clr
);

    reg_addr_e sel;
    logic      frame_wr;

    assign sel      = reg_addr_e'(addr);
    assign frame_wr = wr_en && (sel == RA_FRAME);
    assign stat_clr = rd_en && (sel == RA_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            mask_q   <= '1;
            bb_clk_q <= 1'b0;
            bb_dat_q <= 1'b0;
            bb_oe_q  <= 1'b0;
            frame_q  <= '0;
            pend_q   <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (sel)
                    RA_BB_CLK: bb_clk_q <= wdata[0];
                    RA_BB_DAT: bb_dat_q <= wdata[0];
                    RA_BB_OE:  bb_oe_q  <= wdata[0];
                    RA_CFG: begin
                        cfg_q.bb_sel  <= wdata[0];
                        cfg_q.poll_en <= wdata[1];
                        cfg_q.regad   <= wdata[7:3];
                        cfg_q.phy     <= wdata[14:10];
                    end
                    RA_MASK:   mask_q <= wdata[DATA_BITS-1:0];
                    default: ;
                endcase
            end

            if (frame_wr) begin
                frame_q <= wdata;
                valid_q <= 1'b0;
            end else if (sw_done) begin
                valid_q <= 1'b1;
                if (is_read_op(frame_q))
                    frame_q[DATA_BITS-1:0] <= rx_data;
            end

            if (frame_wr)
                pend_q <= 1'b1;
            else if (sw_launch)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            RA_BB_CLK: rdata[0] = bb_clk_q;
            RA_BB_DAT: rdata[0] = bb_dat_q;
            RA_BB_OE:  rdata[0] = bb_oe_q;
            RA_FRAME:  rdata    = {frame_q[31:17], valid_q, frame_q[15:0]};
            RA_CFG:    rdata    = {17'b0, cfg_q.phy, 2'b0, cfg_q.regad, 1'b0,
                                   cfg_q.poll_en, cfg_q.bb_sel};
            RA_MASK:   rdata    = {16'b0, mask_q};
            RA_STAT:   rdata    = {poll_last, poll_chg};
            default:   rdata    = '0;
        endcase
    end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int CLK_HALF = 2,
    parameter int PRE_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [FRM_BITS-1:0]  word_i,
    input  logic                 mdio_i,
    output logic                 busy_o,
    output logic                 mdc_o,
    output logic                 mdo_o,
    output logic                 oe_o,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] rx_o
);

    localparam int TOT     = PRE_BITS + FRM_BITS;
    localparam int BW      = $clog2(TOT);
    localparam int CW      = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam int REL_POS = PRE_BITS + FRM_BITS - DATA_BITS - 2;
    localparam int DAT_POS = PRE_BITS + FRM_BITS - DATA_BITS;

    logic                 busy_q, mdc_q, rd_q;
    logic [CW-1:0]        cnt_q;
    logic [BW-1:0]        pos_q;
    logic [TOT-1:0]       sh_q;
    logic [DATA_BITS-1:0] rx_q;
    logic                 tick;

    assign tick   = (cnt_q == CW'(CLK_HALF - 1));
    assign done_o = busy_q && tick && mdc_q && (pos_q == BW'(TOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mdc_q  <= 1'b0;
            rd_q   <= 1'b0;
            cnt_q  <= '0;
            pos_q  <= '0;
            sh_q   <= '1;
            rx_q   <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                sh_q   <= {{PRE_BITS{1'b1}}, word_i};
                rd_q   <= is_read_op(word_i);
                cnt_q  <= '0;
                pos_q  <= '0;
                mdc_q  <= 1'b0;
            end
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
            if (!mdc_q) begin
                if (rd_q && (pos_q >= BW'(DAT_POS)))
                    rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
            end else if (pos_q == BW'(TOT - 1)) begin
                busy_q <= 1'b0;
            end else begin
                pos_q <= pos_q + 1'b1;
                sh_q  <= {sh_q[TOT-2:0], 1'b1};
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign mdc_o  = mdc_q;
    assign mdo_o  = busy_q ? sh_q[TOT-1] : 1'b1;
    assign oe_o   = busy_q && !(rd_q && (pos_q >= BW'(REL_POS)));
    assign rx_o   = rx_q;

endmodule

// File: rtl/mdio_poll_track.sv
module mdio_poll_track
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] rx,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] last_o,
    output logic [DATA_BITS-1:0] chg_o
);

    logic                 seen_q;
    logic [DATA_BITS-1:0] last_q, chg_q, diff;

    assign diff = (done && seen_q) ? (rx ^ last_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= '0;
            chg_q  <= '0;
        end else begin
            chg_q <= (clr ? '0 : chg_q) | diff;
            if (done)
                last_q <= rx;
            if (!enable)
                seen_q <= 1'b0;
            else if (done)
                seen_q <= 1'b1;
        end
    end

    assign last_o = last_q;
    assign chg_o  = chg_q;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter int CLK_HALF = 2,
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mdio_i,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              irq_o
);

    cfg_t                 cfg_q;
    logic [DATA_BITS-1:0] mask_q, rx, poll_last, poll_chg;
    logic                 bb_clk_q, bb_dat_q, bb_oe_q;
    logic [FRM_BITS-1:0]  frame_q, tx_word;
    logic                 pend_q, frm_valid, stat_clr;
    logic                 eng_busy, eng_done, launch, cur_poll_q;
    logic                 sw_done, poll_done;
    logic                 e_mdc, e_mdo, e_oe;

    assign launch    = !cfg_q.bb_sel && !eng_busy && (pend_q || cfg_q.poll_en);
    assign tx_word   = pend_q ? frame_q : poll_frame(cfg_q.phy, cfg_q.regad);
    assign sw_done   = eng_done && !cur_poll_q;
    assign poll_done = eng_done && cur_poll_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_poll_q <= 1'b0;
        else if (launch)
            cur_poll_q <= !pend_q;
    end

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .sw_launch (launch && pend_q),
        .sw_done   (sw_done),
        .rx_data   (rx),
        .poll_last (poll_last),
        .poll_chg  (poll_chg),
        .cfg_q     (cfg_q),
        .mask_q    (mask_q),
        .bb_clk_q  (bb_clk_q),
        .bb_dat_q  (bb_dat_q),
        .bb_oe_q   (bb_oe_q),
        .frame_q   (frame_q),
        .pend_q    (pend_q),
        .valid_q   (frm_valid),
        .stat_clr  (stat_clr)
    );

    mdio_shifter #(
        .CLK_HALF (CLK_HALF),
        .PRE_BITS (PRE_BITS)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (launch),
        .word_i  (tx_word),
        .mdio_i  (mdio_i),
        .busy_o  (eng_busy),
        .mdc_o   (e_mdc),
        .mdo_o   (e_mdo),
        .oe_o    (e_oe),
        .done_o  (eng_done),
        .rx_o    (rx)
    );

    mdio_poll_track u_poll (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg_q.poll_en),
        .done   (poll_done),
        .rx     (rx),
        .clr    (stat_clr),
        .last_o (poll_last),
        .chg_o  (poll_chg)
    );

    assign mdc_o   = cfg_q.bb_sel ? bb_clk_q : e_mdc;
    assign mdio_o  = cfg_q.bb_sel ? bb_dat_q : e_mdo;
    assign mdio_oe = cfg_q.bb_sel ? bb_oe_q  : e_oe;
    assign irq_o   = |(poll_chg & ~mask_q);

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic        mdc_o,
    input logic        busy,
    input logic        bb_sel,
    input logic        valid,
    input logic        poll_done,
    input logic [15:0] chg
);

    // R2: outside bit-bang mode MDC only moves while a frame is active
    a_r2_mdc_only_in_frame: assert property (@(posedge clk) disable iff (rst)
        (!bb_sel && $past(!bb_sel) && !$stable(mdc_o)) |-> $past(busy));

    // R7: writing the frame register clears the valid bit
    a_r7_write_clears_valid: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3) |=> !valid);

    // R6: valid only rises at the end of an active frame
    a_r6_valid_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> ($past(busy) && !busy));

    // R8: no frame starts while bit-bang mode is selected
    a_r8_no_launch_bitbang: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(bb_sel));

    // R10: new changed bits appear only when a poll frame completes
    a_r10_change_needs_poll: assert property (@(posedge clk) disable iff (rst)
        ((chg & ~$past(chg)) != 16'h0) |-> $past(poll_done));

endmodule

bind mdio_mgmt_engine mdio_mgmt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mdc_o     (mdc_o),
    .busy      (eng_busy),
    .bb_sel    (cfg_q.bb_sel),
    .valid     (frm_valid),
    .poll_done (poll_done),
    .chg       (poll_chg)
);

// File: tb/mdio_mgmt_engine_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_tb_top;

    localparam int H    = 2;
    localparam int TOTB = 64;
    localparam int FLEN = 2 * H * TOTB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] reg_rdata;
    logic        mdc_o, mdio_o, mdio_oe, irq_o;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    // reference model state
    int          m_e = -1;
    logic [31:0] m_frame, m_word;
    logic        m_valid, m_pend, m_read, m_curpoll, m_seen;
    logic        m_bb, m_pen, m_bbc, m_bbd, m_bbo;
    logic [4:0]  m_pphy, m_preg;
    logic [15:0] m_mask, m_last, m_chg, m_rx;
    logic [15:0] phy_val = 16'h0;

    always #2.5 clk = ~clk;

    mdio_mgmt_engine #(.CLK_HALF(H), .PRE_BITS(32)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .irq_o(irq_o)
    );

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {31'b0, m_bbc};
            3'd1: return {31'b0, m_bbd};
            3'd2: return {31'b0, m_bbo};
            3'd3: return {m_frame[31:17], m_valid, m_frame[15:0]};
            3'd4: return {17'b0, m_pphy, 2'b0, m_preg, 1'b0, m_pen, m_bb};
            3'd5: return {16'b0, m_mask};
            3'd6: return {m_last, m_chg};
            default: return 32'h0;
        endcase
    endfunction

    // behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_e = -1; m_frame = '0; m_word = '0; m_valid = 0; m_pend = 0;
            m_read = 0; m_curpoll = 0; m_seen = 0; m_bb = 0; m_pen = 0;
            m_bbc = 0; m_bbd = 0; m_bbo = 0; m_pphy = 0; m_preg = 0;
            m_mask = 16'hFFFF; m_last = 0; m_chg = 0; m_rx = 0;
        end else begin
            bit busy, go, fin;
            logic [15:0] nchg;
            busy = (m_e >= 0);
            go   = !m_bb && !busy && (m_pend || m_pen);
            fin  = busy && (m_e == FLEN - 1);
            nchg = (reg_rd && reg_addr == 3'd6) ? 16'h0 : m_chg;
            if (fin) begin
                if (m_curpoll) begin
                    if (m_seen) nchg = nchg | (m_rx ^ m_last);
                    m_last = m_rx;
                end else begin
                    m_valid = 1;
                    if (m_read) m_frame[15:0] = m_rx;
                end
            end
            m_chg  = nchg;
            m_seen = m_pen ? (m_seen || (fin && m_curpoll)) : 1'b0;
            if (busy) m_e = fin ? -1 : m_e + 1;
            if (go) begin
                m_e       = 0;
                m_curpoll = !m_pend;
                m_word    = m_pend ? m_frame : {2'b01, 2'b10, m_pphy, m_preg, 2'b10, 16'h0};
                m_read    = (m_word[29:28] == 2'b10);
                m_rx      = phy_val;
                m_pend    = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_bbc = reg_wdata[0];
                    3'd1: m_bbd = reg_wdata[0];
                    3'd2: m_bbo = reg_wdata[0];
                    3'd3: begin m_frame = reg_wdata; m_valid = 0; m_pend = 1; end
                    3'd4: begin
                        m_bb = reg_wdata[0]; m_pen = reg_wdata[1];
                        m_preg = reg_wdata[7:3]; m_pphy = reg_wdata[14:10];
                    end
                    3'd5: m_mask = reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the rising edge; also act as the PHY
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            logic em, eo, ee;
            int b;
            b = (m_e >= 0) ? m_e / (2 * H) : 0;
            if (m_bb) begin
                em = m_bbc; eo = m_bbd; ee = m_bbo;
            end else if (m_e >= 0) begin
                em = ((m_e / H) % 2) == 1;
                eo = (b < 32) ? 1'b1 : m_word[63 - b];
                ee = !(m_read && b >= 46);
            end else begin
                em = 0; eo = 1; ee = 0;
            end
            cmp({31'b0, mdc_o},   {31'b0, em}, "R2 mdc per-cycle");
            cmp({31'b0, mdio_o},  {31'b0, eo}, "R4 mdio_o per-cycle");
            cmp({31'b0, mdio_oe}, {31'b0, ee}, "R5 mdio_oe per-cycle");
            cmp({31'b0, irq_o},   {31'b0, |(m_chg & ~m_mask)}, "R11 irq per-cycle");
            cmp(reg_rdata, exp_rd(reg_addr), "R9 rdata per-cycle");
            if (m_e >= 0 && m_read && b >= 46)
                mdio_i = (b == 46) ? 1'b1 : (b == 47) ? 1'b0 : m_rx[63 - b];
            else
                mdio_i = 1'b1;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        peek(a, d);
        cmp(d, exp, tag);
    endtask

    task automatic wait_valid(input string tag, output int iters);
        logic [31:0] d;
        iters = 0;
        for (int i = 0; i < 3000; i++) begin
            peek(3'd3, d);
            iters = i + 1;
            if (d[16]) break;
        end
        cmp({31'b0, d[16]}, 32'h1, tag);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog R1..all actual=%0d cycles expected=<150000", cyc);
            summary();
        end
    end

    initial begin
        logic [31:0] w, d;
        int ones, rises, first, period, n;
        bit prev, zero_seen;

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        cmp({29'b0, mdc_o, mdio_oe, irq_o}, 32'h0, "R1 pins after reset");
        rd_chk(3'd4, 32'h0, "R1 cfg reset");
        rd_chk(3'd5, 32'h0000FFFF, "R1 mask reset");
        rd_chk(3'd3, 32'h0, "R1 frame reset");
        rd_chk(3'd6, 32'h0, "R1 status reset");

        // write frame: phy 5, reg 2, data A5C3
        w = 32'h50020000 | (32'd5 << 23) | (32'd2 << 18) | 32'hA5C3;
        wr(3'd3, w);
        ones = 0; rises = 0; first = 0; period = 0; prev = 0; zero_seen = 0;
        for (int i = 0; i < 2000 && !zero_seen; i++) begin
            @(negedge clk); #1;
            if (mdc_o && !prev) begin
                rises++;
                if (rises == 1) first = i;
                if (rises == 2) period = i - first;
                if (mdio_o && mdio_oe) ones++; else zero_seen = 1;
            end
            prev = mdc_o;
        end
        cmp(ones, 32, "R3 preamble ones");
        cmp(period, 2 * H, "R2 mdc period");
        wait_valid("R7 write frame completes", n);
        rd_chk(3'd3, {w[31:17], 1'b1, w[15:0]}, "R6 write keeps data");

        // read frame: phy 1, reg 4
        phy_val = 16'h3C5A;
        w = 32'h60020000 | (32'd1 << 23) | (32'd4 << 18);
        wr(3'd3, w);
        wait_valid("R6 read frame completes", n);
        rd_chk(3'd3, {w[31:17], 1'b1, 16'h3C5A}, "R6 read capture");

        // bit-bang
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h1); wr(3'd1, 32'h0); wr(3'd2, 32'h1);
        @(negedge clk); #1;
        cmp({29'b0, mdc_o, mdio_o, mdio_oe}, 32'b101, "R8 pins follow bit-bang");
        w = 32'h50020000 | (32'd3 << 23) | 32'h0F0F;
        wr(3'd3, w);
        repeat (400) @(negedge clk);
        #1 cmp({29'b0, mdc_o, mdio_o, mdio_oe}, 32'b101, "R8 no frame in bit-bang");
        rd_chk(3'd3, {w[31:17], 1'b0, w[15:0]}, "R7 valid cleared and held");
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wait_valid("R8 held frame sent after exit", n);

        // poll mode
        wr(3'd5, 32'h0000FF00);
        phy_val = 16'h1111;
        wr(3'd4, 32'h2 | (32'd3 << 3) | (32'd7 << 10));
        repeat (600) @(negedge clk);
        #1 cmp({31'b0, irq_o}, 32'h0, "R10 first poll no irq");
        rd_chk(3'd6, {16'h1111, 16'h0000}, "R9 last polled value");
        phy_val = 16'h1131;
        repeat (600) @(negedge clk);
        #1 cmp({31'b0, irq_o}, 32'h1, "R11 unmasked change irq");
        rd_chk(3'd6, {16'h1131, 16'h0020}, "R10 changed bits");
        @(negedge clk); #1;
        cmp({31'b0, irq_o}, 32'h0, "R10 read clears changes");
        phy_val = 16'h9131;
        repeat (600) @(negedge clk);
        #1 cmp({31'b0, irq_o}, 32'h0, "R11 masked change no irq");
        rd_chk(3'd6, {16'h9131, 16'h8000}, "R11 masked bit still reported");

        // software frame during polling
        phy_val = 16'h7E81;
        w = 32'h60020000 | (32'd2 << 23) | (32'd1 << 18);
        wr(3'd3, w);
        wait_valid("R12 queued frame completes", n);
        cmp({31'b0, (2 * n <= 2 * FLEN + 40)}, 32'h1, "R12 frame waits at most one poll");
        rd_chk(3'd3, {w[31:17], 1'b1, 16'h7E81}, "R12 queued read data");
        wr(3'd4, 32'h0);
        repeat (FLEN + 20) @(negedge clk);
        #1 cmp({31'b0, mdc_o}, 32'h0, "R2 mdc idle low");
        summary();
    end

endmodule